// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a single video output port. A horizontal counter runs in pixel clocks and a vertical counter runs in lines. From these it derives horizontal sync, vertical sync and a data-enable strobe, each with a programmable active level, plus a flag that tells the pad logic to invert the pixel clock. A post stage after the counters chooses the pixel value. It can pass the upstream layer's pixel, fill with a programmable background colour when the layer has nothing valid, draw a colour-bar test pattern, force black, or force every output pin to zero. A request strobe tells the upstream layer which cycles need a pixel.

Software writes registers through a one-cycle write port with a 4-bit word address. Every write lands in a shadow copy. The shadow copy moves to the working set only after a commit write addressed to this port. While the port is running, the transfer happens at the next frame boundary, so a frame never mixes two configurations. All positions are absolute counts from the start of the sync pulse.

Top module: `raster_timing_gen`

## Requirements
- R1: Writes go to shadow storage: address 0 control, 1 polarity, 2 background, 3 pattern, 4 horizontal total, 5 horizontal active, 6 vertical total, 7 vertical active. They have no effect on any output until address 8 is written with both bit PORT_ID and bit PORT_ID+16 set. A commit word with only one of these two bits set, or with only bit 15 set, is ignored.
- R2: After a commit, the shadow set becomes active at the frame wrap: the cycle where the horizontal counter is at total-1 and the vertical counter is at total-1. If the active set is in standby, the shadow set becomes active on the next clock instead. A shadow write made in the same cycle as the transfer is not part of the transferred set.
- R3: Horizontal total holds the sync width in [12:0] and the line period in [28:16]. Vertical total uses the same layout in lines. The horizontal counter runs 0 to period-1, and the vertical counter advances when the horizontal counter wraps. Horizontal sync is asserted while h < sync width, and vertical sync while v < sync width. Outputs are registered one cycle after the counter state they reflect.
- R4: Active registers hold the start in [28:16] and the end in [12:0]. Data-enable is asserted when start ≤ counter < end on both axes. pix_req is the same condition, combinational and one cycle ahead of de_o, and it is low in standby.
- R5: Polarity bits: bit0 set makes hsync active high (clear means active low), bit1 does the same for vsync, bit2 set makes data-enable active low, and bit3 drives pclk_inv_o.
- R6: Control bit 31 (standby) holds both counters at 0 and drives hsync and vsync at their inactive levels, data-enable inactive and pixel data at zero. Standby takes priority over every force bit.
- R7: Control bit 26 (force zero) drives hsync_o, vsync_o, de_o and pix_out to 0, whatever the polarity setting. It takes priority over force black.
- R8: Control bit 27 (force black) makes pixel data zero while sync and data-enable keep running normally.
- R9: Pattern bit0 enables colour bars. Bit1 clear divides the bars by horizontal position and bit1 set divides them by line. The bar index is ((pos - start) >> BAR_SHIFT) mod 8. Red is full scale when index bit0 is set, green when index bit1 is set, and blue when index bit2 is set. Otherwise each channel is zero.
- R10: During active area with the pattern off and pix_valid low, each channel shows the 6-bit background field (red [25:20], green [15:10], blue [5:0]) followed by CHW-6 zero bits. Outside the active area the pixel data is zero.
- R11: When control bits [3:0] equal 15, all bits of each channel pass through. Any other value clears the two least significant bits of each channel. pix_out packs red in the top CHW bits, then green, then blue.
- R12: After reset the port is in standby with polarity 0: hsync_o=1, vsync_o=1, de_o=0, pclk_inv_o=0, pix_out=0, pix_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream layer has a valid pixel this cycle |
| pix_in | input | 3*CHW | Upstream pixel {red, green, blue} |
| pix_req | output | 1 | Active-area pixel request to upstream |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| pix_out | output | 3*CHW | Output pixel {red, green, blue} |

## Verification
The main collision is a register action that lands in the same cycle as the frame wrap that transfers a pending commit. In one case a shadow write arrives in that cycle; in the other a fresh commit does. The bench waits until its own model reports a wrap cycle and issues the control write on exactly that edge. It then checks that the frame which follows uses the earlier force-black setting, not the new force-zero value, and that the new value appears only after another commit and one more wrap. Mid-frame commits with random timing and polarity are checked in the same way: every output is compared against the model on every cycle, so any change before the boundary is caught.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int FW  = 13;
   localparam int CBW = 6;
   localparam int DW  = 32;

   typedef enum logic [3:0] {
      A_CTRL   = 4'd0,
      A_POL    = 4'd1,
      A_BG     = 4'd2,
      A_BAR    = 4'd3,
      A_HTOT   = 4'd4,
      A_HACT   = 4'd5,
      A_VTOT   = 4'd6,
      A_VACT   = 4'd7,
      A_COMMIT = 4'd8
   } rtg_addr_e;

   typedef struct packed {
      logic           stby;
      logic           blk;
      logic           zro;
      logic [3:0]     fmt;
      logic [3:0]     pol;
      logic [CBW-1:0] bgr;
      logic [CBW-1:0] bgg;
      logic [CBW-1:0] bgb;
      logic           bar_en;
      logic           bar_mode;
      logic [FW-1:0]  hsw;
      logic [FW-1:0]  hper;
      logic [FW-1:0]  hst;
      logic [FW-1:0]  hend;
      logic [FW-1:0]  vsw;
      logic [FW-1:0]  vper;
      logic [FW-1:0]  vst;
      logic [FW-1:0]  vend;
   } rtg_cfg_t;

   localparam rtg_cfg_t CFG_RST = '{stby: 1'b1, default: '0};
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int PORT_ID = 0,
   parameter int AW      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            frame_wrap,
   output rtg_cfg_t        act_cfg,
   output logic            pend
);
   localparam int MASK_POS = PORT_ID + DW/2;
   localparam int HI_POS   = DW/2;

   rtg_cfg_t   shd;
   logic       hi_zero;
   logic [3:0] sel;
   logic       commit_hit;
   logic       load;
   logic       unused_wd;

   assign sel = wr_addr[3:0];

   generate
      if (AW > 4) begin : g_wide_addr
         assign hi_zero = (wr_addr[AW-1:4] == '0);
      end else begin : g_narrow_addr
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign unused_wd  = ^wr_data;
   assign commit_hit = wr_en && hi_zero && (sel == A_COMMIT) &&
                       wr_data[PORT_ID] && wr_data[MASK_POS];
   assign load       = pend && (act_cfg.stby || frame_wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd <= CFG_RST;
      end else if (wr_en && hi_zero) begin
         case (sel)
            A_CTRL: begin
               shd.stby <= wr_data[31];
               shd.blk  <= wr_data[27];
               shd.zro  <= wr_data[26];
               shd.fmt  <= wr_data[3:0];
            end
            A_POL: shd.pol <= wr_data[3:0];
            A_BG: begin
               shd.bgr <= wr_data[20 +: CBW];
               shd.bgg <= wr_data[10 +: CBW];
               shd.bgb <= wr_data[0 +: CBW];
            end
            A_BAR: begin
               shd.bar_en   <= wr_data[0];
               shd.bar_mode <= wr_data[1];
            end
            A_HTOT: begin
               shd.hsw  <= wr_data[0 +: FW];
               shd.hper <= wr_data[HI_POS +: FW];
            end
            A_HACT: begin
               shd.hend <= wr_data[0 +: FW];
               shd.hst  <= wr_data[HI_POS +: FW];
            end
            A_VTOT: begin
               shd.vsw  <= wr_data[0 +: FW];
               shd.vper <= wr_data[HI_POS +: FW];
            end
            A_VACT: begin
               shd.vend <= wr_data[0 +: FW];
               shd.vst  <= wr_data[HI_POS +: FW];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg <= CFG_RST;
         pend    <= 1'b0;
      end else begin
         if (load) act_cfg <= shd;
         if (commit_hit)  pend <= 1'b1;
         else if (load)   pend <= 1'b0;
      end
   end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
   import rtg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  rtg_cfg_t      act_cfg,
   output logic [FW-1:0] h_cnt,
   output logic [FW-1:0] v_cnt,
   output logic          frame_wrap
);
   localparam int FW1 = FW + 1;

   logic h_last;
   logic v_last;
   logic unused_cfg;

   assign unused_cfg = ^{act_cfg.blk, act_cfg.zro, act_cfg.fmt, act_cfg.pol,
                         act_cfg.bgr, act_cfg.bgg, act_cfg.bgb, act_cfg.bar_en,
                         act_cfg.bar_mode, act_cfg.hsw, act_cfg.hst, act_cfg.hend,
                         act_cfg.vsw, act_cfg.vst, act_cfg.vend};

   assign h_last     = ({1'b0, h_cnt} + FW1'(1)) >= {1'b0, act_cfg.hper};
   assign v_last     = ({1'b0, v_cnt} + FW1'(1)) >= {1'b0, act_cfg.vper};
   assign frame_wrap = !act_cfg.stby && h_last && v_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (act_cfg.stby) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else begin
         h_cnt <= h_last ? '0 : h_cnt + FW'(1);
         if (h_last) v_cnt <= v_last ? '0 : v_cnt + FW'(1);
      end
   end
endmodule

// File: rtl/rtg_post.sv
module rtg_post
   import rtg_pkg::*;
#(
   parameter int CHW       = 10,
   parameter int BAR_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rtg_cfg_t         act_cfg,
   input  logic [FW-1:0]    h_cnt,
   input  logic [FW-1:0]    v_cnt,
   input  logic             pix_valid,
   input  logic [3*CHW-1:0] pix_in,
   output logic             pix_req,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic             pclk_inv_o,
   output logic [3*CHW-1:0] pix_out
);
   localparam int PW = 3 * CHW;

   logic           hs_on, vs_on, h_act, v_act, de_on;
   logic [FW-1:0]  bar_off;
   logic [2:0]     bar_idx;
   logic [CBW-1:0] bg_arr [3];
   logic [PW-1:0]  pix_nxt;
   logic           unused_cfg;

   assign unused_cfg = ^{act_cfg.hper, act_cfg.vper, bar_off};

   assign hs_on   = h_cnt < act_cfg.hsw;
   assign vs_on   = v_cnt < act_cfg.vsw;
   assign h_act   = (h_cnt >= act_cfg.hst) && (h_cnt < act_cfg.hend);
   assign v_act   = (v_cnt >= act_cfg.vst) && (v_cnt < act_cfg.vend);
   assign de_on   = !act_cfg.stby && h_act && v_act;
   assign pix_req = de_on;

   assign bar_off = act_cfg.bar_mode ? (v_cnt - act_cfg.vst) : (h_cnt - act_cfg.hst);
   assign bar_idx = bar_off[BAR_SHIFT +: 3];

   assign bg_arr[0] = act_cfg.bgb;
   assign bg_arr[1] = act_cfg.bgg;
   assign bg_arr[2] = act_cfg.bgr;

   genvar gi;
   generate
      for (gi = 0; gi < 3; gi++) begin : g_ch
         logic [CHW-1:0] bar_v;
         logic [CHW-1:0] bg_v;
         logic [CHW-1:0] src_v;
         logic [CHW-1:0] fmt_v;

         assign bar_v = {CHW{bar_idx[2-gi]}};
         assign bg_v  = {bg_arr[gi], {(CHW-CBW){1'b0}}};

         always_comb begin
            if (act_cfg.blk || act_cfg.zro) src_v = '0;
            else if (act_cfg.bar_en)        src_v = bar_v;
            else if (!pix_valid)            src_v = bg_v;
            else                            src_v = pix_in[gi*CHW +: CHW];
         end

         assign fmt_v = (act_cfg.fmt == 4'hF) ? src_v : {src_v[CHW-1:2], 2'b00};
         assign pix_nxt[gi*CHW +: CHW] = de_on ? fmt_v : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o    <= 1'b1;
         vsync_o    <= 1'b1;
         de_o       <= 1'b0;
         pclk_inv_o <= 1'b0;
         pix_out    <= '0;
      end else begin
         pclk_inv_o <= act_cfg.pol[3];
         if (act_cfg.stby) begin
            hsync_o <= !act_cfg.pol[0];
            vsync_o <= !act_cfg.pol[1];
            de_o    <= act_cfg.pol[2];
            pix_out <= '0;
         end else if (act_cfg.zro) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            pix_out <= '0;
         end else begin
            hsync_o <= act_cfg.pol[0] ? hs_on : !hs_on;
            vsync_o <= act_cfg.pol[1] ? vs_on : !vs_on;
            de_o    <= act_cfg.pol[2] ? !de_on : de_on;
            pix_out <= pix_nxt;
         end
      end
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int PORT_ID   = 0,
   parameter int AW        = 4,
   parameter int CHW       = 10,
   parameter int BAR_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [31:0]      wr_data,
   input  logic             pix_valid,
   input  logic [3*CHW-1:0] pix_in,
   output logic             pix_req,
   output logic             hsync_o,
   output logic             vsync_o,
   output logic             de_o,
   output logic             pclk_inv_o,
   output logic [3*CHW-1:0] pix_out
);
   generate
      if (PORT_ID < 0 || PORT_ID > 3) begin : g_bad_port
         $error("PORT_ID must be in 0..3");
      end
      if (AW < 4) begin : g_bad_aw
         $error("AW must be at least 4");
      end
      if (CHW <= CBW) begin : g_bad_chw
         $error("CHW must exceed the background field width");
      end
      if (BAR_SHIFT + 3 > FW) begin : g_bad_shift
         $error("BAR_SHIFT too large for counter width");
      end
   endgenerate

   rtg_cfg_t      act_cfg;
   logic          commit_pend;
   logic [FW-1:0] h_cnt;
   logic [FW-1:0] v_cnt;
   logic          frame_wrap;

   rtg_regs #(.PORT_ID(PORT_ID), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_wrap(frame_wrap), .act_cfg(act_cfg),
      .pend(commit_pend)
   );

   rtg_counters u_cnt (
      .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg),
      .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_wrap(frame_wrap)
   );

   rtg_post #(.CHW(CHW), .BAR_SHIFT(BAR_SHIFT)) u_post (
      .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg), .h_cnt(h_cnt),
      .v_cnt(v_cnt), .pix_valid(pix_valid), .pix_in(pix_in),
      .pix_req(pix_req), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .de_o(de_o), .pclk_inv_o(pclk_inv_o), .pix_out(pix_out)
   );
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
   import rtg_pkg::*;
#(
   parameter int PORT_ID = 0,
   parameter int AW      = 4,
   parameter int CHW     = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic [31:0]      wr_data,
   input logic             pix_req,
   input logic             hsync_o,
   input logic             vsync_o,
   input logic             de_o,
   input logic [3*CHW-1:0] pix_out,
   input rtg_cfg_t         act_cfg,
   input logic             commit_pend,
   input logic [FW-1:0]    h_cnt,
   input logic [FW-1:0]    v_cnt,
   input logic             frame_wrap
);
   // R1: a pending commit only ever starts from a qualified commit write
   assert_commit_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_pend) |-> $past(wr_en && wr_addr == AW'(8) &&
                                   wr_data[PORT_ID] && wr_data[PORT_ID+16]));

   // R2: the working set is frozen inside a running frame
   assert_no_midframe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_cfg.stby && !frame_wrap) |=> $stable(act_cfg));

   // R3: counters stay below their programmed periods
   assert_h_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.hper != '0) |-> (h_cnt < act_cfg.hper));
   assert_v_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.vper != '0) |-> (v_cnt < act_cfg.vper));

   // R4: a request is followed by data-enable at its active level
   assert_req_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && !act_cfg.zro) |=> (de_o != $past(act_cfg.pol[2])));

   // R6: standby clears the counters and silences requests
   assert_stby_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_cfg.stby |=> (h_cnt == '0 && v_cnt == '0));
   assert_stby_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_cfg.stby |-> !pix_req);

   // R7: force zero drives every output pin low
   assert_zero_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_cfg.stby && act_cfg.zro) |=> (!hsync_o && !vsync_o && !de_o && pix_out == '0));
endmodule

bind raster_timing_gen rtg_chk #(.PORT_ID(PORT_ID), .AW(AW), .CHW(CHW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .pix_req(pix_req), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
   .pix_out(pix_out), .act_cfg(act_cfg), .commit_pend(commit_pend),
   .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_wrap(frame_wrap)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
   localparam int CHW = 10;
   localparam int BS  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          pix_valid = 1'b0;
   logic [29:0]   pix_in = '0;
   logic          pix_req, hsync_o, vsync_o, de_o, pclk_inv_o;
   logic [29:0]   pix_out;

   raster_timing_gen #(.PORT_ID(0), .AW(4), .CHW(CHW), .BAR_SHIFT(BS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_valid(pix_valid), .pix_in(pix_in), .pix_req(pix_req), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .pclk_inv_o(pclk_inv_o), .pix_out(pix_out)
   );

   always #4 clk = ~clk;

   typedef struct {
      int stby, blk, zro, fmt, pol, bgr, bgg, bgb, bar_en, bar_mode;
      int hsw, hper, hst, hend, vsw, vper, vst, vend;
   } mc_t;

   mc_t m_shd, m_act;
   int  mh, mv, m_pend, cyc;
   int  errs = 0, checks = 0;
   bit  e_hs, e_vs, e_de, e_pc;
   logic [29:0] e_pix;
   string phase = "R12";

   function automatic mc_t rst_cfg();
      mc_t c = '{default: 0};
      c.stby = 1;
      return c;
   endfunction

   function automatic logic [29:0] pat(int n);
      logic [31:0] x;
      x = 32'(n) * 32'h9E3779B1;
      return x[29:0] ^ x[31:2];
   endfunction

   function automatic bit vld(int n);
      return (n % 5) != 3;
   endfunction

   function automatic mc_t apply_wr(mc_t s, int a, logic [31:0] d);
      mc_t r = s;
      case (a)
         0: begin r.stby = d[31]; r.blk = d[27]; r.zro = d[26]; r.fmt = int'(d[3:0]); end
         1: r.pol = int'(d[3:0]);
         2: begin r.bgr = int'(d[25:20]); r.bgg = int'(d[15:10]); r.bgb = int'(d[5:0]); end
         3: begin r.bar_en = d[0]; r.bar_mode = d[1]; end
         4: begin r.hsw = int'(d[12:0]); r.hper = int'(d[28:16]); end
         5: begin r.hend = int'(d[12:0]); r.hst = int'(d[28:16]); end
         6: begin r.vsw = int'(d[12:0]); r.vper = int'(d[28:16]); end
         7: begin r.vend = int'(d[12:0]); r.vst = int'(d[28:16]); end
         default: ;
      endcase
      return r;
   endfunction

   function automatic bit in_act(mc_t c, int h, int v);
      return c.stby == 0 && h >= c.hst && h < c.hend && v >= c.vst && v < c.vend;
   endfunction

   function automatic logic [29:0] exp_pix(mc_t c, int h, int v, bit val, logic [29:0] pin);
      logic [29:0] r = '0;
      logic [9:0]  sv;
      int off, idx, bgv;
      if (c.zro != 0 || !in_act(c, h, v)) return '0;
      for (int ch = 0; ch < 3; ch++) begin
         if (c.blk != 0) sv = '0;
         else if (c.bar_en != 0) begin
            off = (c.bar_mode != 0) ? v - c.vst : h - c.hst;
            idx = (off >> BS) & 7;
            sv  = (((idx >> (2 - ch)) & 1) != 0) ? 10'h3FF : 10'h000;
         end else if (!val) begin
            bgv = (ch == 2) ? c.bgr : (ch == 1) ? c.bgg : c.bgb;
            sv  = 10'(bgv << 4);
         end else sv = pin[ch*10 +: 10];
         if (c.fmt != 15) sv = sv & 10'h3FC;
         r[ch*10 +: 10] = sv;
      end
      return r;
   endfunction

   task automatic chk(string tag, string nm, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, nm, got, exp, cyc);
      end
   endtask

   // one clock: drive at the current negedge, advance the model, compare at the next negedge
   task automatic tick(bit we, int a, logic [31:0] d);
      bit hl, vl, wrap, load, commit, hs_on, vs_on, de_on;
      int nh, nv;
      wr_en = we; wr_addr = 4'(a); wr_data = d;
      pix_valid = vld(cyc); pix_in = pat(cyc);
      hs_on = mh < m_act.hsw;
      vs_on = mv < m_act.vsw;
      de_on = in_act(m_act, mh, mv);
      e_pc  = (m_act.pol >> 3) & 1;
      if (m_act.stby != 0) begin
         e_hs = !((m_act.pol & 1) != 0); e_vs = !(((m_act.pol >> 1) & 1) != 0);
         e_de = (m_act.pol >> 2) & 1; e_pix = '0;
      end else if (m_act.zro != 0) begin
         e_hs = 0; e_vs = 0; e_de = 0; e_pix = '0;
      end else begin
         e_hs  = ((m_act.pol & 1) != 0) ? hs_on : !hs_on;
         e_vs  = (((m_act.pol >> 1) & 1) != 0) ? vs_on : !vs_on;
         e_de  = (((m_act.pol >> 2) & 1) != 0) ? !de_on : de_on;
         e_pix = exp_pix(m_act, mh, mv, pix_valid, pix_in);
      end
      hl = (mh + 1) >= m_act.hper;
      vl = (mv + 1) >= m_act.vper;
      wrap = (m_act.stby == 0) && hl && vl;
      load = (m_pend != 0) && (m_act.stby != 0 || wrap);
      commit = we && a == 8 && d[0] && d[16];
      if (m_act.stby != 0) begin nh = 0; nv = 0; end
      else begin nh = hl ? 0 : mh + 1; nv = hl ? (vl ? 0 : mv + 1) : mv; end
      @(posedge clk);
      mh = nh; mv = nv;
      if (load) m_act = m_shd;
      m_pend = commit ? 1 : (load ? 0 : m_pend);
      if (we) m_shd = apply_wr(m_shd, a, d);
      cyc++;
      @(negedge clk);
      chk("R3/R5", "hsync", hsync_o, e_hs);
      chk("R3/R5", "vsync", vsync_o, e_vs);
      chk("R4/R5", "de", de_o, e_de);
      chk("R5", "pclk_inv", pclk_inv_o, e_pc);
      chk(phase, "pix_out", pix_out, e_pix);
      chk("R4", "pix_req", pix_req, in_act(m_act, mh, mv));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0);
   endtask

   task automatic write_timing(int hsw, int hper, int hst, int hend,
                               int vsw, int vper, int vst, int vend);
      tick(1, 4, (32'(hper) << 16) | 32'(hsw));
      tick(1, 5, (32'(hst) << 16) | 32'(hend));
      tick(1, 6, (32'(vper) << 16) | 32'(vsw));
      tick(1, 7, (32'(vst) << 16) | 32'(vend));
   endtask

   function automatic logic [31:0] ctrl_w(bit st, bit bk, bit zr, int fmt);
      return (32'(st) << 31) | (32'(bk) << 27) | (32'(zr) << 26) | 32'(fmt & 15);
   endfunction

   task automatic wait_wrap_edge();
      while (!(m_act.stby == 0 && (mh + 1) >= m_act.hper && (mv + 1) >= m_act.vper))
         tick(0, 0, 0);
   endtask

   initial begin
      #1_200_000;
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int hper, hsw, hst, hend, vper, vsw, vst, vend;
      void'($urandom(32'd4711));
      m_shd = rst_cfg(); m_act = rst_cfg(); mh = 0; mv = 0; m_pend = 0; cyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset levels
      chk("R12", "hsync", hsync_o, 1);
      chk("R12", "vsync", vsync_o, 1);
      chk("R12", "de", de_o, 0);
      chk("R12", "pclk_inv", pclk_inv_o, 0);
      chk("R12", "pix_out", pix_out, 0);
      chk("R12", "pix_req", pix_req, 0);

      // R1: shadow writes and unqualified commits change nothing
      phase = "R1";
      write_timing(2, 16, 4, 12, 1, 6, 2, 5);
      tick(1, 0, ctrl_w(0, 0, 0, 15));
      tick(1, 2, (32'd21 << 20) | (32'd42 << 10) | 32'd7);
      idle(6);
      tick(1, 8, 32'h0000_8000);
      tick(1, 8, 32'h0000_0001);
      tick(1, 8, 32'h0001_0000);
      idle(6);
      chk("R1", "still idle hsync", hsync_o, 1);
      chk("R1", "still idle req", pix_req, 0);

      // R3 R4 R10 R11: qualified commit starts the port
      phase = "R3/R10/R11";
      tick(1, 8, 32'h0001_8001);
      idle(2 * 16 * 6 + 4);

      // R2 R5 R9 R11: random configurations committed mid-frame
      for (int it = 0; it < 6; it++) begin
         phase = "R2/R9/R11";
         hper = 12 + int'($urandom_range(0, 12));
         hsw  = 1 + int'($urandom_range(0, 2));
         hst  = hsw + 1 + int'($urandom_range(0, 1));
         hend = hst + 4 + int'($urandom_range(0, 4));
         vper = 5 + int'($urandom_range(0, 3));
         vsw  = 1;
         vst  = 2;
         vend = vst + 2 + int'($urandom_range(0, 1));
         idle(int'($urandom_range(3, 40)));
         write_timing(hsw, hper, hst, hend, vsw, vper, vst, vend);
         tick(1, 1, 32'($urandom_range(0, 15)));
         tick(1, 3, 32'($urandom_range(0, 3)));
         tick(1, 2, $urandom);
         tick(1, 0, ctrl_w(0, 0, 0, (it % 2 == 0) ? 15 : int'($urandom_range(0, 14))));
         tick(1, 8, 32'h0001_0001);
         idle(2 * 24 * 8 + 10);
      end

      // R8 then R2 collision: force-zero written in the wrap cycle is not loaded
      phase = "R8";
      tick(1, 3, 0);
      tick(1, 1, 0);
      tick(1, 0, ctrl_w(0, 1, 0, 15));
      tick(1, 8, 32'h0001_0001);
      wait_wrap_edge();
      phase = "R2/R8";
      tick(1, 0, ctrl_w(0, 0, 1, 15));
      chk("R2", "black frame keeps de running", m_act.zro, 0);
      idle(24 * 8);

      // R7: commit of force-zero lands on the following wrap
      phase = "R7";
      wait_wrap_edge();
      tick(1, 8, 32'h0001_0001);
      idle(24 * 8 + 4);
      tick(1, 1, 32'h7);
      tick(1, 8, 32'h0001_0001);
      idle(24 * 8 * 2);
      chk("R7", "zero hsync", hsync_o, 0);
      chk("R7", "zero pix", pix_out, 0);

      // R6: standby via commit
      phase = "R6";
      tick(1, 0, ctrl_w(1, 0, 0, 15));
      tick(1, 8, 32'h0001_0001);
      idle(24 * 8 * 2 + 4);
      chk("R6", "standby req", pix_req, 0);
      chk("R6", "standby de inactive (active low)", de_o, 1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule